// File: doc/BRIEF.md
# Gapped Clock T1 Rate Adapter

This block moves a T1 bit stream between two timings: a 1.544 Mbit/s line rate and a 2.048 MHz clock in which 63 of every 256 slots carry no data. Both timings are modelled inside one system clock by single-cycle strobes. In the transmit direction, bits arrive on a gapped strobe and data pair. They leave on a steady base-rate strobe. In the receive direction, a steady line-rate stream is written in and read out only on the pulses of an externally supplied gapped strobe. The gaps in that strobe therefore decide where the output gaps fall.

Each direction has an eight-entry elastic FIFO with its own enable input. At enable time the FIFO starts half full of zero bits. This absorbs the phase wander between the gapped strobe and the steady strobe. Overflow and underflow are recorded as sticky flags.

While a direction is disabled, its FIFO is held flushed and its flags are cleared. Its output register then loads the input bit directly on every output strobe. A separate select input switches a reference strobe output between a base-rate tick and a tick at 32 times that rate.

Top module: `gap_rate_adapter`

## Requirements
- R1: While rstN is low, both data outputs, all four sticky flags and refStbOut are 0.
- R2: With a direction's enable at 0, a pulse on its output strobe loads its input data bit into its data output at the next clock edge. Otherwise the output holds its value.
- R3: After a direction's enable goes from 0 to 1, its first four pops return 0. Later pops return the written bits in arrival order. A pop is an output strobe while the FIFO is not empty, and the output changes at the clock edge of the strobe.
- R4: A write strobe while the FIFO holds 8 bits and no output strobe is present drops the bit and sets the overflow flag. The flag stays at 1 while the direction is enabled.
- R5: An output strobe while the FIFO is empty leaves the data output at its last bit and sets the underflow flag.
- R6: A write and an output strobe in the same cycle on a full FIFO both take effect, and no overflow is flagged. On an empty FIFO in the same cycle, underflow is flagged and the written bit is still stored for the next pop.
- R7: While a direction is disabled, its overflow and underflow flags read 0. Re-enabling restores the four-zero prefill.
- R8: The two directions are independent. One enabled direction does not change the bypass behaviour of the other.
- R9: refStbOut equals fastTick from the previous cycle when refFastSel was 1, and baseTick from the previous cycle when it was 0.
- R10: With 193 write strobes evenly spread per 256 slots and a steady strobe of the same average rate, a pseudo-random stream crosses both directions with no bit lost or changed, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txGapEn | input | 1 | Transmit gapped mode enable |
| rxGapEn | input | 1 | Receive gapped mode enable |
| refFastSel | input | 1 | 1 selects the 32x reference tick |
| baseTick | input | 1 | Base-rate reference tick |
| fastTick | input | 1 | 32x reference tick |
| refStbOut | output | 1 | Registered reference strobe |
| txGapStb | input | 1 | Transmit gapped clock strobe (write) |
| txGapData | input | 1 | Transmit gapped data bit |
| txBaseStb | input | 1 | Transmit steady 1.544 MHz strobe (read) |
| txLineData | output | 1 | Transmit line data |
| txOvf | output | 1 | Transmit sticky overflow |
| txUnf | output | 1 | Transmit sticky underflow |
| rxBaseStb | input | 1 | Receive steady line strobe (write) |
| rxLineData | input | 1 | Receive line data bit |
| rxGapStb | input | 1 | Receive external gapped strobe (read) |
| rxGapData | output | 1 | Receive gapped data |
| rxOvf | output | 1 | Receive sticky overflow |
| rxUnf | output | 1 | Receive sticky underflow |

## Verification
A write and a read can land in the same cycle. This matters most at the two FIFO limits, where either an overflow or an underflow could be raised. The bench fills the transmit FIFO to eight bits, then pulses both strobes together. It expects a prefill zero on the output and no overflow. It then drains the FIFO to empty, pulses both strobes again, and expects underflow with the output held. The following pop must then return the bit written in that same cycle. A long run with interleaved gapped and steady strobes compares every output bit against a queue model built in the bench.

// File: rtl/gap_rate_pkg.sv
package gap_rate_pkg;
  // Per-cycle commands from FIFO control to FIFO datapath
  typedef struct packed {
    logic push;      // store input bit at write pointer
    logic pop;       // load output from read pointer
    logic flush;     // clear storage and recentre pointers
    logic bypassLd;  // load output straight from input
  } fifoStb_t;
endpackage

// File: rtl/gap_fifo_ctl.sv
module gap_fifo_ctl
  import gap_rate_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  input  logic     inStb,
  input  logic     outStb,
  output fifoStb_t ctl,
  output logic     ovf,
  output logic     unf
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned HALF  = DEPTH / 2;

  logic [CNT_W-1:0] fillCnt;
  logic full;
  logic empty;

  always_comb begin
    full         = (fillCnt == CNT_W'(DEPTH));
    empty        = (fillCnt == '0);
    ctl.flush    = !en;
    ctl.bypassLd = !en && outStb;
    ctl.push     = en && inStb && (!full || outStb);
    ctl.pop      = en && outStb && !empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      fillCnt <= CNT_W'(HALF);
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else begin
      fillCnt <= fillCnt + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
      if (inStb && full && !outStb) ovf <= 1'b1;
      if (outStb && empty)          unf <= 1'b1;
    end
  end
endmodule

// File: rtl/gap_fifo_data.sv
module gap_fifo_data
  import gap_rate_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  fifoStb_t ctl,
  input  logic     inData,
  output logic     outData
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned HALF  = DEPTH / 2;

  logic [DEPTH-1:0] store;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      store <= '0;
      wrPtr <= PTR_W'(HALF);
      rdPtr <= '0;
    end else begin
      if (ctl.push) begin
        store[wrPtr] <= inData;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (ctl.pop) rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outData <= 1'b0;
    else if (ctl.bypassLd) outData <= inData;
    else if (ctl.pop)      outData <= store[rdPtr];
  end
endmodule

// File: rtl/gap_rate_adapter.sv
module gap_rate_adapter
  import gap_rate_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic txGapEn,
  input  logic rxGapEn,
  input  logic refFastSel,
  input  logic baseTick,
  input  logic fastTick,
  output logic refStbOut,
  input  logic txGapStb,
  input  logic txGapData,
  input  logic txBaseStb,
  output logic txLineData,
  output logic txOvf,
  output logic txUnf,
  input  logic rxBaseStb,
  input  logic rxLineData,
  input  logic rxGapStb,
  output logic rxGapData,
  output logic rxOvf,
  output logic rxUnf
);
  localparam int unsigned NDIR = 2;  // index 0 transmit, 1 receive

  logic [NDIR-1:0] dirEn, inStb, inBit, outStb, outBit, ovfF, unfF;

  assign dirEn  = {rxGapEn, txGapEn};
  assign inStb  = {rxBaseStb, txGapStb};
  assign inBit  = {rxLineData, txGapData};
  assign outStb = {rxGapStb, txBaseStb};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    fifoStb_t stb;
    gap_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
      .clk(clk), .rstN(rstN), .en(dirEn[d]), .inStb(inStb[d]),
      .outStb(outStb[d]), .ctl(stb), .ovf(ovfF[d]), .unf(unfF[d])
    );
    gap_fifo_data #(.DEPTH(DEPTH)) u_dat (
      .clk(clk), .rstN(rstN), .ctl(stb), .inData(inBit[d]),
      .outData(outBit[d])
    );
  end

  assign txLineData = outBit[0];
  assign rxGapData  = outBit[1];
  assign txOvf = ovfF[0];
  assign txUnf = unfF[0];
  assign rxOvf = ovfF[1];
  assign rxUnf = unfF[1];

  always_ff @(posedge clk) begin
    if (!rstN) refStbOut <= 1'b0;
    else       refStbOut <= refFastSel ? fastTick : baseTick;
  end
endmodule

// File: rtl/gap_rate_adapter_chk.sv
module gap_rate_adapter_chk (
  input logic clk,
  input logic rstN,
  input logic txGapEn,
  input logic rxGapEn,
  input logic refFastSel,
  input logic baseTick,
  input logic fastTick,
  input logic refStbOut,
  input logic txGapData,
  input logic txBaseStb,
  input logic txLineData,
  input logic txOvf,
  input logic txUnf,
  input logic rxBaseStb,
  input logic rxLineData,
  input logic rxGapStb,
  input logic rxGapData,
  input logic rxOvf,
  input logic rxUnf
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!txOvf && !txUnf && !rxOvf && !rxUnf && !refStbOut));

  // R2
  a_r2_tx_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (!txGapEn && txBaseStb) |=> (txLineData == $past(txGapData)));
  a_r2_rx_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (!rxGapEn && rxGapStb) |=> (rxGapData == $past(rxLineData)));

  // R4
  a_r4_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txOvf && txGapEn) |=> txOvf);
  a_r4_rx_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvf && rxGapEn) |=> rxOvf);

  // R5
  a_r5_tx_unf_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txUnf) |-> (txLineData == $past(txLineData)));
  a_r5_rx_unf_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxUnf) |-> (rxGapData == $past(rxGapData)));

  // R7
  a_r7_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    !txGapEn |=> (!txOvf && !txUnf));
  a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    !rxGapEn |=> (!rxOvf && !rxUnf));

  // R9
  a_r9_ref_select: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (refStbOut == $past(refFastSel ? fastTick : baseTick)));
endmodule

bind gap_rate_adapter gap_rate_adapter_chk u_chk (
  .clk(clk), .rstN(rstN), .txGapEn(txGapEn), .rxGapEn(rxGapEn),
  .refFastSel(refFastSel), .baseTick(baseTick), .fastTick(fastTick),
  .refStbOut(refStbOut), .txGapData(txGapData), .txBaseStb(txBaseStb),
  .txLineData(txLineData), .txOvf(txOvf), .txUnf(txUnf),
  .rxBaseStb(rxBaseStb), .rxLineData(rxLineData), .rxGapStb(rxGapStb),
  .rxGapData(rxGapData), .rxOvf(rxOvf), .rxUnf(rxUnf)
);

// File: tb/gap_rate_adapter_tb.sv
module gap_rate_adapter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txGapEn = 0, rxGapEn = 0, refFastSel = 0, baseTick = 0, fastTick = 0;
  logic txGapStb = 0, txGapData = 0, txBaseStb = 0;
  logic rxBaseStb = 0, rxLineData = 0, rxGapStb = 0;
  logic refStbOut, txLineData, txOvf, txUnf, rxGapData, rxOvf, rxUnf;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gap_rate_adapter u_dut (
    .clk(clk), .rstN(rstN), .txGapEn(txGapEn), .rxGapEn(rxGapEn),
    .refFastSel(refFastSel), .baseTick(baseTick), .fastTick(fastTick),
    .refStbOut(refStbOut), .txGapStb(txGapStb), .txGapData(txGapData),
    .txBaseStb(txBaseStb), .txLineData(txLineData), .txOvf(txOvf),
    .txUnf(txUnf), .rxBaseStb(rxBaseStb), .rxLineData(rxLineData),
    .rxGapStb(rxGapStb), .rxGapData(rxGapData), .rxOvf(rxOvf), .rxUnf(rxUnf)
  );

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one cycle of transmit strobes: write (gapped), read (steady)
  task automatic txCyc(logic wr, logic d, logic rd);
    txGapStb = wr; txGapData = d; txBaseStb = rd;
    step();
    txGapStb = 0; txBaseStb = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [0:7] expQ;
    logic [14:0] txLfsr, rxLfsr;
    logic txQ[$];
    logic rxQ[$];
    int accB;
    int gapPrev, gapNow;
    logic gapSlot, baseSlot, tb, rb, ev;

    repeat (3) step();
    // R1 reset state
    chk("R1 txLineData", txLineData, 0);
    chk("R1 rxGapData", rxGapData, 0);
    chk("R1 flags", txOvf | txUnf | rxOvf | rxUnf, 0);
    chk("R1 refStbOut", refStbOut, 0);
    rstN = 1;
    step();

    // R9 reference strobe select
    baseTick = 1; fastTick = 0; refFastSel = 0; step();
    chk("R9 base tick", refStbOut, 1);
    refFastSel = 1; step();
    chk("R9 fast tick low", refStbOut, 0);
    fastTick = 1; baseTick = 0; step();
    chk("R9 fast tick high", refStbOut, 1);
    refFastSel = 0; step();
    chk("R9 back to base", refStbOut, 0);
    fastTick = 0;

    // R2 bypass, both disabled
    txCyc(0, 1, 1);
    chk("R2 tx bypass load 1", txLineData, 1);
    txGapData = 0; step();
    chk("R2 tx holds without strobe", txLineData, 1);
    rxLineData = 1; rxGapStb = 1; step(); rxGapStb = 0;
    chk("R2 rx bypass load 1", rxGapData, 1);

    // R3/R4/R6 transmit enabled
    txGapEn = 1; step();
    chk("R7 flags clear at enable", txOvf | txUnf, 0);
    txCyc(1, 1, 0); txCyc(1, 0, 0); txCyc(1, 1, 0); txCyc(1, 1, 0);
    chk("R4 no overflow at exactly full", txOvf, 0);
    // R8 rx still in bypass while tx enabled
    rxLineData = 0; rxGapStb = 1; step(); rxGapStb = 0;
    chk("R8 rx bypass with tx enabled", rxGapData, 0);
    txCyc(1, 1, 1);
    chk("R6 full write+read pops prefill", txLineData, 0);
    chk("R6 full write+read no overflow", txOvf, 0);
    txCyc(1, 0, 0);
    chk("R4 overflow flagged", txOvf, 1);
    expQ = 8'b0001_0111;
    for (int i = 0; i < 8; i++) begin
      txCyc(0, 0, 1);
      chk($sformatf("R3 pop %0d order", i), txLineData, expQ[i]);
    end
    chk("R4 overflow sticky", txOvf, 1);
    chk("R5 no underflow yet", txUnf, 0);
    txCyc(0, 0, 1);
    chk("R5 underflow flagged", txUnf, 1);
    chk("R5 output repeats last bit", txLineData, 1);
    txCyc(1, 0, 1);
    chk("R6 empty write+read holds output", txLineData, 1);
    txCyc(0, 0, 1);
    chk("R6 bit written at empty is kept", txLineData, 0);

    // R7 disable flushes and recentres
    txGapEn = 0; step();
    chk("R7 overflow cleared", txOvf, 0);
    chk("R7 underflow cleared", txUnf, 0);
    txCyc(0, 1, 1);
    chk("R2 tx bypass after disable", txLineData, 1);
    txGapEn = 1; step();
    for (int i = 0; i < 4; i++) begin
      txCyc(0, 1, 1);
      chk($sformatf("R7 prefill zero %0d", i), txLineData, 0);
    end
    txCyc(0, 1, 1);
    chk("R7 empty after prefill", txUnf, 1);

    // R10 end to end with evenly spread gaps
    txGapEn = 0; rxGapEn = 0; step();
    txGapEn = 1; rxGapEn = 1; step();
    txLfsr = 15'h1; rxLfsr = 15'h5A5A;
    repeat (4) begin txQ.push_back(1'b0); rxQ.push_back(1'b0); end
    accB = 128;
    for (int f = 0; f < 30; f++) begin
      for (int s = 0; s < 256; s++) begin
        gapPrev = (s * 193) / 256;
        gapNow  = ((s + 1) * 193) / 256;
        gapSlot = (gapNow != gapPrev);
        accB += 193;
        baseSlot = (accB >= 256);
        if (baseSlot) accB -= 256;
        tb = txLfsr[14] ^ txLfsr[13];
        rb = rxLfsr[14] ^ rxLfsr[13];
        txGapStb = gapSlot; txGapData = tb; txBaseStb = baseSlot;
        rxBaseStb = baseSlot; rxLineData = rb; rxGapStb = gapSlot;
        step();
        txGapStb = 0; txBaseStb = 0; rxBaseStb = 0; rxGapStb = 0;
        if (baseSlot) begin
          ev = txQ.pop_front();
          chk("R10 tx stream bit", txLineData, ev);
        end
        if (gapSlot) begin
          txQ.push_back(tb);
          txLfsr = {txLfsr[13:0], tb};
          ev = rxQ.pop_front();
          chk("R10 rx stream bit", rxGapData, ev);
        end
        if (baseSlot) begin
          rxQ.push_back(rb);
          rxLfsr = {rxLfsr[13:0], rb};
        end
        step();
      end
    end
    chk("R10 tx no flags", txOvf | txUnf, 0);
    chk("R10 rx no flags", rxOvf | rxUnf, 0);
    finish();
  end
endmodule